// File: doc/BRIEF.md
# Framed ROM address mapper

This block places 2 KB of byte-wide nonvolatile storage behind an 8-bit CPU address space. The CPU loads an address register and a frame register from its data bus, each on its own active-low strobe. CPU addresses below 128 always land in the bottom 128 bytes of storage, whatever frame is selected. Addresses of 128 and above use the low four frame bits as the upper part of the storage address. Any of the sixteen 128-byte frames can therefore be reached, while a routine held in the bottom frame stays visible at all times.

One frame bit hands the whole window to an external I/O port. While that bit is set, the storage neither answers reads nor accepts writes. The port pins carry the current address, the full frame value, a clock and an enable. The CPU side is a plain strobe bus with no valid/ready flow: each strobe is one clock long and cannot be stalled. The read path is combinational from the registered address, so a read strobe gets its data within the same cycle.

Top module: `frame_rom_mapper`

## Requirements
- R1: After reset, io_addr is 0x00, io_bank is 0x00, io_en is 0 and bus_drive is 0. Frame 0 and the storage are selected.
- R2: When adr_ld_n is low at a rising clock edge, the address register takes bus_in. Its value appears on io_addr.
- R3: When frm_ld_n is low at a rising clock edge, the frame register takes bus_in. All 8 bits appear on io_bank, and bit 4 appears on io_en.
- R4: When wr_n is low at a rising edge and frame bit 4 is 0, bus_in is stored at the mapped storage address.
- R5: While rd_n is low and frame bit 4 is 0, bus_drive is 1 and bus_out shows the byte at the mapped storage address.
- R6: For an address with bit 7 clear, the mapped storage address is the low 7 address bits with upper bits 0, so frame 0 is reached for any frame value.
- R7: For an address with bit 7 set, the mapped storage address is frame bits [3:0] times 128 plus address bits [6:0]. Address 0xFF with frame 15 reaches the last byte, 2047.
- R8: While frame bit 4 is 1, bus_drive stays 0 even during a read, and writes leave the storage unchanged.
- R9: io_clk follows the block clock.
- R10: With both load strobes high, io_addr and io_bank hold their values whatever bus_in does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_in | input | 8 | Data bus into the block |
| adr_ld_n | input | 1 | Address register load strobe, active low |
| frm_ld_n | input | 1 | Frame register load strobe, active low |
| rd_n | input | 1 | Storage read strobe, active low |
| wr_n | input | 1 | Storage write strobe, active low |
| bus_out | output | 8 | Read data, zero when not driving |
| bus_drive | output | 1 | High while bus_out should be placed on the bus |
| io_addr | output | 8 | Current address register, for the external port |
| io_bank | output | 8 | Current frame register, for the external port |
| io_clk | output | 1 | Clock forwarded to the external port |
| io_en | output | 1 | External port enable, frame bit 4 |

## Verification
The bench builds the block with its default parameters: an 8-bit address, a 4-bit bank field, the port switch on frame bit 4, and 2048 storage bytes. These settings let the bench reach both window edges (0x7F and 0x80), the first and last frames, and storage byte 2047. They also let it toggle the port bit between writes, which shows that a write made while the port is enabled never reaches storage.

// File: rtl/frm_pkg.sv
package frm_pkg;
  typedef enum logic {SEL_STORE = 1'b0, SEL_PORT = 1'b1} frm_sel_e;
endpackage

// File: rtl/frm_reg.sv
module frm_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (!ld_n) q <= d;
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_n |=> $stable(q));
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_n |=> q == $past(d));
endmodule

// File: rtl/frm_map.sv
module frm_map
  import frm_pkg::*;
#(
  parameter int AW  = 8,
  parameter int BW  = 4,
  localparam int OW = AW - 1,
  localparam int SW = BW + OW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic [BW-1:0] bank,
  input  logic          port_bit,
  input  logic          rd_n,
  input  logic          wr_n,
  output logic [SW-1:0] phys,
  output logic          st_we,
  output logic          st_re
);
  frm_sel_e sel;
  logic [BW-1:0] eff_bank;

  assign sel      = port_bit ? SEL_PORT : SEL_STORE;
  assign eff_bank = cpu_addr[AW-1] ? bank : '0;
  assign phys     = {eff_bank, cpu_addr[OW-1:0]};
  assign st_we    = (sel == SEL_STORE) && !wr_n;
  assign st_re    = (sel == SEL_STORE) && !rd_n;

  assert_low_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_addr[AW-1] |-> phys[SW-1:OW] == '0);
  assert_port_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    port_bit |-> !st_we && !st_re);
endmodule

// File: rtl/frm_store.sv
module frm_store #(
  parameter int SW = 11,
  parameter int DW = 8,
  localparam int DEPTH = 1 << SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] a,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] rdat
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[a] <= wd;
  end

  assign rdat = mem[a];

  assert_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(a)] == $past(wd));
endmodule

// File: rtl/frame_rom_mapper.sv
module frame_rom_mapper #(
  parameter int AW      = 8,
  parameter int BW      = 4,
  parameter int PORT_IX = 4,
  localparam int DW     = AW,
  localparam int SW     = BW + AW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] bus_in,
  input  logic          adr_ld_n,
  input  logic          frm_ld_n,
  input  logic          rd_n,
  input  logic          wr_n,
  output logic [DW-1:0] bus_out,
  output logic          bus_drive,
  output logic [AW-1:0] io_addr,
  output logic [DW-1:0] io_bank,
  output logic          io_clk,
  output logic          io_en
);
  logic [AW-1:0] adr_q;
  logic [DW-1:0] frm_q;
  logic [SW-1:0] phys;
  logic          st_we, st_re;
  logic [DW-1:0] rdat;

  frm_reg #(.W(AW)) u_adr (.clk(clk), .rst_n(rst_n), .ld_n(adr_ld_n), .d(bus_in), .q(adr_q));
  frm_reg #(.W(DW)) u_frm (.clk(clk), .rst_n(rst_n), .ld_n(frm_ld_n), .d(bus_in), .q(frm_q));

  frm_map #(.AW(AW), .BW(BW)) u_map (
    .clk(clk), .rst_n(rst_n), .cpu_addr(adr_q), .bank(frm_q[BW-1:0]),
    .port_bit(frm_q[PORT_IX]), .rd_n(rd_n), .wr_n(wr_n),
    .phys(phys), .st_we(st_we), .st_re(st_re));

  frm_store #(.SW(SW), .DW(DW)) u_st (
    .clk(clk), .rst_n(rst_n), .we(st_we), .a(phys), .wd(bus_in), .rdat(rdat));

  assign bus_drive = st_re;
  assign bus_out   = st_re ? rdat : '0;
  assign io_addr   = adr_q;
  assign io_bank   = frm_q;
  assign io_en     = frm_q[PORT_IX];
  assign io_clk    = clk;

  assert_no_drive_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
    io_en |-> !bus_drive);
  assert_read_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && !io_en) |-> bus_drive);
endmodule

// File: tb/frame_rom_mapper_tb.sv
module frame_rom_mapper_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] bus_in = '0;
  logic adr_ld_n = 1'b1, frm_ld_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] bus_out, io_addr, io_bank;
  logic bus_drive, io_clk, io_en;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct { logic drive; logic [7:0] data; string req; } exp_t;
  exp_t exp_q[$];
  logic [7:0] model [int];
  logic [7:0] cur_a = '0, cur_f = '0;

  frame_rom_mapper dut_i (.clk(clk), .rst_n(rst_n), .bus_in(bus_in), .adr_ld_n(adr_ld_n),
    .frm_ld_n(frm_ld_n), .rd_n(rd_n), .wr_n(wr_n), .bus_out(bus_out), .bus_drive(bus_drive),
    .io_addr(io_addr), .io_bank(io_bank), .io_clk(io_clk), .io_en(io_en));

  always #(CLK_P/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int phys_of(logic [7:0] a, logic [7:0] f);
    return a[7] ? (int'(f[3:0]) * 128 + int'(a[6:0])) : int'(a[6:0]);
  endfunction

  task automatic load_addr(logic [7:0] v);
    @(negedge clk); adr_ld_n = 1'b0; bus_in = v;
    @(negedge clk); adr_ld_n = 1'b1; cur_a = v;
    check("R2 io_addr", io_addr, v);
  endtask

  task automatic load_frame(logic [7:0] v);
    @(negedge clk); frm_ld_n = 1'b0; bus_in = v;
    @(negedge clk); frm_ld_n = 1'b1; cur_f = v;
    check("R3 io_bank", io_bank, v);
    check("R3 io_en", io_en, v[4]);
  endtask

  task automatic write_byte(logic [7:0] v);
    @(negedge clk); wr_n = 1'b0; bus_in = v;
    @(negedge clk); wr_n = 1'b1;
    if (!cur_f[4]) model[phys_of(cur_a, cur_f)] = v;
  endtask

  task automatic read_byte(string req);
    exp_t e;
    e.req = req;
    e.drive = !cur_f[4];
    e.data = e.drive ? model[phys_of(cur_a, cur_f)] : 8'h00;
    @(negedge clk); rd_n = 1'b0; exp_q.push_back(e);
    @(negedge clk); rd_n = 1'b1;
  endtask

  // monitor: samples a quarter period after the rising edge
  always @(posedge clk) begin
    #(CLK_P/4);
    check("R9 io_clk high", io_clk, 1'b1);
    if (!rd_n && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check({e.req, " drive"}, bus_drive, e.drive);
      if (e.drive) check({e.req, " data"}, bus_out, e.data);
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 io_addr", io_addr, 8'h00);
    check("R1 io_bank", io_bank, 8'h00);
    check("R1 io_en", io_en, 1'b0);
    check("R1 bus_drive", bus_drive, 1'b0);
    check("R9 io_clk low", io_clk, 1'b0);

    // R4/R5: simple write and read in frame 0
    load_addr(8'h10); write_byte(8'hAA); read_byte("R5 frame0");
    load_addr(8'h7F); write_byte(8'h5C); read_byte("R5 edge 0x7F");
    // R6: low window ignores frame
    load_frame(8'h09); load_addr(8'h10); read_byte("R6 low window f9");
    load_addr(8'h7F); read_byte("R6 low window 0x7F");
    load_frame(8'h0F); load_addr(8'h10); write_byte(8'h3E);
    load_frame(8'h00); read_byte("R6 low write in f15 reaches f0");
    // R7: high window banked
    for (int f = 0; f < 16; f += 5) begin
      load_frame(8'(f)); load_addr(8'h85); write_byte(8'(8'h40 + f));
    end
    load_frame(8'h02); load_addr(8'h85); write_byte(8'h22);
    load_frame(8'h03); load_addr(8'h85); write_byte(8'h33);
    load_frame(8'h02); read_byte("R7 frame2");
    load_frame(8'h03); read_byte("R7 frame3");
    load_frame(8'h0A); read_byte("R7 frame10");
    load_frame(8'h00); load_addr(8'h80); write_byte(8'h81); read_byte("R7 edge 0x80 f0");
    load_frame(8'h0F); load_addr(8'hFF); write_byte(8'hE7); read_byte("R7 last byte");
    load_frame(8'h0F); load_addr(8'h85); read_byte("R7 frame15");
    // R8: port mode blocks reads and writes
    load_frame(8'h13); load_addr(8'h85); write_byte(8'h99); read_byte("R8 port read");
    load_addr(8'h10); write_byte(8'h77);
    load_frame(8'h03); load_addr(8'h85); read_byte("R8 write ignored high");
    load_addr(8'h10); read_byte("R8 write ignored low");
    // R10: hold with strobes high
    @(negedge clk); bus_in = 8'hC3;
    repeat (3) @(negedge clk);
    check("R10 io_addr hold", io_addr, 8'h10);
    check("R10 io_bank hold", io_bank, 8'h03);
    repeat (2) @(negedge clk);
    check("R5 queue drained", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule